// File: doc/BRIEF.md
# Multicycle Processor Step Controller

This block is the sequencing brain of a multicycle 32-bit processor whose datapath shares a single memory for instructions and data, uses one ALU for every arithmetic job, and keeps intermediate values in holding registers: instruction, memory data, the two operand registers and the ALU result register. The controller walks through one step per clock. Each step drives the strobes and multiplexer selects that the datapath needs for that cycle. The step that follows depends on the current step and on the opcode field from the instruction register.

Every instruction begins with a fetch step and a decode step. After that it takes its own path. A load runs for five cycles, a store and a register-register operation for four, and a branch and a jump for three. During decode the ALU computes the branch target ahead of time and parks it in the ALU result register. The branch step then compares the operands by subtraction and requests a PC write that the datapath commits only when the ALU reports zero. If the opcode is not recognised, decode sends the machine back to fetch and raises a one-cycle illegal-instruction flag. All outputs come straight from flops. Any signal a step does not call for is driven low.

Top module: `mcyc_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sets `step` to 0 (fetch) at the next rising edge, puts all control outputs in their fetch values and clears `illegal`. A reset given in the middle of an instruction abandons that instruction.
- R2: In step 0 (fetch): `mem_rd`=1, `ir_wr`=1, `pc_wr`=1, `addr_sel`=0 (PC addresses memory), `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant 4), `alu_op`=00 (add), `pc_src`=00 (live ALU result). Step 1 always follows.
- R3: In step 1 (decode): `alu_a_sel`=0, `alu_b_sel`=11 (shifted immediate), `alu_op`=00, and no strobe is asserted. The next step is chosen by the opcode: 0x23 (load) or 0x2B (store) go to step 2, 0x00 (register-register) goes to 6, 0x04 (branch) goes to 8, and 0x02 (jump) goes to 9.
- R4: A load runs through steps 0,1,2,3,4, which is five cycles. Step 2: `alu_a_sel`=1 (register A), `alu_b_sel`=10 (immediate), `alu_op`=00. Step 3: `mem_rd`=1, `addr_sel`=1. Step 4: `reg_wr`=1, `mem_to_reg`=1, `reg_dst`=0.
- R5: A store runs through steps 0,1,2,5, which is four cycles. Step 5: `mem_wr`=1, `addr_sel`=1.
- R6: A register-register instruction runs through steps 0,1,6,7. Step 6: `alu_a_sel`=1, `alu_b_sel`=00 (register B), `alu_op`=10 (function field). Step 7: `reg_wr`=1, `reg_dst`=1, `mem_to_reg`=0.
- R7: A branch runs through steps 0,1,8. Step 8: `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01 (subtract), `pc_wr_cond`=1, `pc_src`=01 (ALU result register), `pc_wr`=0.
- R8: A jump runs through steps 0,1,9. Step 9: `pc_wr`=1, `pc_src`=10 (jump target).
- R9: In every step, each output not listed for that step is 0, and `mem_rd` and `mem_wr` are never high together.
- R10: An opcode outside the five listed in R3, seen in step 1, sends the machine to step 0. `illegal` is 1 for exactly that fetch cycle and 0 in every other cycle.
- R11: The opcode is looked at only in step 1 and step 2 (in step 2, 0x2B selects step 5 and any other value selects step 3). Opcode values in any other step do not change the sequence or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| step | output | 4 | Current step number |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write gated by the ALU zero flag |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU result register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| alu_a_sel | output | 1 | ALU input 1: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU input 2: 00 B, 01 four, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| reg_dst | output | 1 | Destination field: 0 rt, 1 rd |
| mem_to_reg | output | 1 | Write-back data: 0 ALU result register, 1 memory data |
| reg_wr | output | 1 | Register file write |
| illegal | output | 1 | One-cycle unknown-opcode flag |

## Verification
The illegal-opcode flag and the fetch step for the next instruction always happen in the same cycle: `illegal` goes high while fetch is already asserting its memory read, instruction load and PC write. The bench provokes this by holding unknown opcodes through decode, both in isolation and mixed at random into a stream of legal instructions. A behavioural model expects the flag and the full set of fetch strobes together in that one cycle, and the flag low again in the cycle after. The same stream also changes the opcode freely outside decode and address compute, so that the opcode-sampling rule is checked while these overlaps are happening.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  localparam int SW = 4;

  typedef enum logic [SW-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_MADDR  = 4'd2,
    ST_LDRD   = 4'd3,
    ST_LDWB   = 4'd4,
    ST_STWR   = 4'd5,
    ST_REXE   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BRC    = 4'd8,
    ST_JMP    = 4'd9
  } step_e;

  localparam logic       ASRC_PC    = 1'b0;
  localparam logic       ASRC_A     = 1'b1;
  localparam logic [1:0] BSRC_REG   = 2'b00;
  localparam logic [1:0] BSRC_FOUR  = 2'b01;
  localparam logic [1:0] BSRC_IMM   = 2'b10;
  localparam logic [1:0] BSRC_IMMSH = 2'b11;
  localparam logic [1:0] AOP_ADD    = 2'b00;
  localparam logic [1:0] AOP_SUB    = 2'b01;
  localparam logic [1:0] AOP_FUNCT  = 2'b10;
  localparam logic [1:0] PSRC_ALU   = 2'b00;
  localparam logic [1:0] PSRC_HOLD  = 2'b01;
  localparam logic [1:0] PSRC_JUMP  = 2'b10;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
    logic       reg_dst;
    logic       mem_to_reg;
    logic       reg_wr;
  } ctrl_t;

  localparam ctrl_t CTRL_FETCH = '{
    pc_wr: 1'b1, pc_wr_cond: 1'b0, addr_sel: 1'b0, mem_rd: 1'b1,
    mem_wr: 1'b0, ir_wr: 1'b1, alu_a_sel: ASRC_PC, alu_b_sel: BSRC_FOUR,
    alu_op: AOP_ADD, pc_src: PSRC_ALU, reg_dst: 1'b0, mem_to_reg: 1'b0,
    reg_wr: 1'b0};
endpackage

// File: rtl/mcyc_next.sv
module mcyc_next
  import mcyc_pkg::*;
#(
  parameter int             OPW       = 6,
  parameter logic [OPW-1:0] OP_ALU    = 6'h00,
  parameter logic [OPW-1:0] OP_LOAD   = 6'h23,
  parameter logic [OPW-1:0] OP_STORE  = 6'h2B,
  parameter logic [OPW-1:0] OP_BRANCH = 6'h04,
  parameter logic [OPW-1:0] OP_JUMP   = 6'h02
) (
  input  step_e          cur,
  input  logic [OPW-1:0] op,
  output step_e          nxt,
  output logic           bad_op
);
  always_comb begin
    nxt    = ST_FETCH;
    bad_op = 1'b0;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (op == OP_LOAD || op == OP_STORE) nxt = ST_MADDR;
        else if (op == OP_ALU)               nxt = ST_REXE;
        else if (op == OP_BRANCH)            nxt = ST_BRC;
        else if (op == OP_JUMP)              nxt = ST_JMP;
        else begin
          nxt    = ST_FETCH;
          bad_op = 1'b1;
        end
      end
      ST_MADDR:  nxt = (op == OP_STORE) ? ST_STWR : ST_LDRD;
      ST_LDRD:   nxt = ST_LDWB;
      ST_REXE:   nxt = ST_RWB;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcyc_decode.sv
module mcyc_decode
  import mcyc_pkg::*;
(
  input  step_e st,
  output ctrl_t c
);
  always_comb begin
    c = '0;
    case (st)
      ST_FETCH:  c = CTRL_FETCH;
      ST_DECODE: begin
        c.alu_a_sel = ASRC_PC;
        c.alu_b_sel = BSRC_IMMSH;
        c.alu_op    = AOP_ADD;
      end
      ST_MADDR: begin
        c.alu_a_sel = ASRC_A;
        c.alu_b_sel = BSRC_IMM;
        c.alu_op    = AOP_ADD;
      end
      ST_LDRD: begin
        c.mem_rd   = 1'b1;
        c.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        c.reg_wr     = 1'b1;
        c.mem_to_reg = 1'b1;
        c.reg_dst    = 1'b0;
      end
      ST_STWR: begin
        c.mem_wr   = 1'b1;
        c.addr_sel = 1'b1;
      end
      ST_REXE: begin
        c.alu_a_sel = ASRC_A;
        c.alu_b_sel = BSRC_REG;
        c.alu_op    = AOP_FUNCT;
      end
      ST_RWB: begin
        c.reg_wr  = 1'b1;
        c.reg_dst = 1'b1;
      end
      ST_BRC: begin
        c.alu_a_sel  = ASRC_A;
        c.alu_b_sel  = BSRC_REG;
        c.alu_op     = AOP_SUB;
        c.pc_wr_cond = 1'b1;
        c.pc_src     = PSRC_HOLD;
      end
      ST_JMP: begin
        c.pc_wr  = 1'b1;
        c.pc_src = PSRC_JUMP;
      end
      default: c = '0;
    endcase
  end
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
#(
  parameter int             OPW       = 6,
  parameter logic [OPW-1:0] OP_ALU    = 6'h00,
  parameter logic [OPW-1:0] OP_LOAD   = 6'h23,
  parameter logic [OPW-1:0] OP_STORE  = 6'h2B,
  parameter logic [OPW-1:0] OP_BRANCH = 6'h04,
  parameter logic [OPW-1:0] OP_JUMP   = 6'h02
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output logic [3:0]     step,
  output logic           pc_wr,
  output logic           pc_wr_cond,
  output logic           addr_sel,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           ir_wr,
  output logic           alu_a_sel,
  output logic [1:0]     alu_b_sel,
  output logic [1:0]     alu_op,
  output logic [1:0]     pc_src,
  output logic           reg_dst,
  output logic           mem_to_reg,
  output logic           reg_wr,
  output logic           illegal
);
  step_e cur_q, nxt;
  ctrl_t nxt_c, ctl_q;
  logic  bad_op, ill_q;

  mcyc_next #(
    .OPW(OPW), .OP_ALU(OP_ALU), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
    .OP_BRANCH(OP_BRANCH), .OP_JUMP(OP_JUMP)
  ) u_next (
    .cur(cur_q), .op(opcode), .nxt(nxt), .bad_op(bad_op)
  );

  // Outputs are decoded from the next step so flops line up with the step.
  mcyc_decode u_dec (.st(nxt), .c(nxt_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= ST_FETCH;
      ctl_q <= CTRL_FETCH;
      ill_q <= 1'b0;
    end else begin
      cur_q <= nxt;
      ctl_q <= nxt_c;
      ill_q <= bad_op;
    end
  end

  assign step       = cur_q;
  assign pc_wr      = ctl_q.pc_wr;
  assign pc_wr_cond = ctl_q.pc_wr_cond;
  assign addr_sel   = ctl_q.addr_sel;
  assign mem_rd     = ctl_q.mem_rd;
  assign mem_wr     = ctl_q.mem_wr;
  assign ir_wr      = ctl_q.ir_wr;
  assign alu_a_sel  = ctl_q.alu_a_sel;
  assign alu_b_sel  = ctl_q.alu_b_sel;
  assign alu_op     = ctl_q.alu_op;
  assign pc_src     = ctl_q.pc_src;
  assign reg_dst    = ctl_q.reg_dst;
  assign mem_to_reg = ctl_q.mem_to_reg;
  assign reg_wr     = ctl_q.reg_wr;
  assign illegal    = ill_q;

  // R2
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_q == ST_FETCH) |=> (cur_q == ST_DECODE));

  // R4
  tail_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_q inside {ST_LDWB, ST_STWR, ST_RWB, ST_BRC, ST_JMP}) |=> (cur_q == ST_FETCH));

  // R7
  cond_write_src_chk: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |-> (pc_src == PSRC_HOLD && !pc_wr && alu_op == AOP_SUB));

  // R9
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R10
  illegal_origin_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (cur_q == ST_FETCH && $past(cur_q) == ST_DECODE));

  // R10
  illegal_single_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |=> !illegal);
endmodule

// File: tb/sim_mcyc_ctrl.sv
module sim_mcyc_ctrl;
  localparam logic [5:0] OPC_ALU = 6'h00, OPC_LD = 6'h23, OPC_ST = 6'h2B,
                         OPC_BR = 6'h04, OPC_J = 6'h02;

  logic clk = 1'b0, rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic [3:0] step;
  logic pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  logic reg_dst, mem_to_reg, reg_wr, illegal;

  mcyc_ctrl u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .step(step), .pc_wr(pc_wr),
    .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .ir_wr(ir_wr), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src),
    .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .reg_wr(reg_wr),
    .illegal(illegal)
  );

  always #10 clk = ~clk;

  int  checks = 0, errors = 0, cyc = 0;
  int  m_state = 0;
  bit  m_ill = 1'b0, checking = 1'b0, scram = 1'b0;

  function automatic bit known_op(logic [5:0] op);
    return op == OPC_ALU || op == OPC_LD || op == OPC_ST || op == OPC_BR || op == OPC_J;
  endfunction

  function automatic int model_next(int s, logic [5:0] op);
    if (s == 0) return 1;
    if (s == 1) begin
      if (op == OPC_LD || op == OPC_ST) return 2;
      if (op == OPC_ALU) return 6;
      if (op == OPC_BR) return 8;
      if (op == OPC_J) return 9;
      return 0;
    end
    if (s == 2) return (op == OPC_ST) ? 5 : 3;
    if (s == 3) return 4;
    if (s == 6) return 7;
    return 0;
  endfunction

  // {pc_wr,pc_wr_cond,addr_sel,mem_rd,mem_wr,ir_wr,alu_a,alu_b,alu_op,pc_src,reg_dst,mem_to_reg,reg_wr,illegal}
  function automatic logic [16:0] model_out(int s, bit ill);
    logic pw = 0, pwc = 0, ad = 0, mr = 0, mw = 0, iw = 0, aa = 0;
    logic [1:0] ab = 0, ao = 0, ps = 0;
    logic rd = 0, m2r = 0, rw = 0;
    if (s == 0) begin mr = 1; iw = 1; pw = 1; ab = 2'b01; end
    else if (s == 1) ab = 2'b11;
    else if (s == 2) begin aa = 1; ab = 2'b10; end
    else if (s == 3) begin mr = 1; ad = 1; end
    else if (s == 4) begin rw = 1; m2r = 1; end
    else if (s == 5) begin mw = 1; ad = 1; end
    else if (s == 6) begin aa = 1; ao = 2'b10; end
    else if (s == 7) begin rw = 1; rd = 1; end
    else if (s == 8) begin aa = 1; ao = 2'b01; pwc = 1; ps = 2'b01; end
    else if (s == 9) begin pw = 1; ps = 2'b10; end
    return {pw, pwc, ad, mr, mw, iw, aa, ab, ao, ps, rd, m2r, rw, ill};
  endfunction

  function automatic string tag_of(int s, bit ill, bit r, bit scr);
    string t;
    if (r) t = "R1";
    else if (ill) t = "R10";
    else if (s == 0) t = "R2";
    else if (s == 1) t = "R3";
    else if (s >= 2 && s <= 4) t = "R4";
    else if (s == 5) t = "R5";
    else if (s == 6 || s == 7) t = "R6";
    else if (s == 8) t = "R7";
    else t = "R8";
    t = {t, " R9"};
    if (scr) t = {t, " R11"};
    return t;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state <= 0;
      m_ill   <= 1'b0;
    end else begin
      m_state <= model_next(m_state, opcode);
      m_ill   <= (m_state == 1) && !known_op(opcode);
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      logic [16:0] got, exp;
      got = {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, alu_a_sel,
             alu_b_sel, alu_op, pc_src, reg_dst, mem_to_reg, reg_wr, illegal};
      exp = model_out(m_state, m_ill);
      checks++;
      if (got !== exp || step !== 4'(m_state)) begin
        errors++;
        $display("FAIL %s: step %0d ctrl %05h, expected step %0d ctrl %05h",
                 tag_of(m_state, m_ill, rst, scram), step, got, m_state, exp);
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL R2 watchdog: step %0d actual, fetch 0 expected in time", step);
      summary();
      $finish;
    end
  end

  // Called at a falling edge while the model sits in fetch.
  task automatic issue(input logic [5:0] op, input bit scr);
    scram  = scr;
    opcode = scr ? 6'($urandom) : op;
    @(negedge clk);
    while (m_state != 0) begin
      if (m_state == 1 || m_state == 2) opcode = op;
      else opcode = scr ? 6'($urandom) : op;
      @(negedge clk);
    end
    scram = 1'b0;
  endtask

  initial begin
    logic [5:0] legal [5] = '{OPC_ALU, OPC_LD, OPC_ST, OPC_BR, OPC_J};
    @(posedge clk);
    checking = 1'b1;           // R1: reset values checked from here
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R4 R5 R6 R7 R8: each instruction class, twice
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < 5; i++) issue(legal[i], 1'b0);
    // R10: unknown opcodes, also back to back
    issue(6'h3F, 1'b0);
    issue(6'h01, 1'b0);
    issue(6'h10, 1'b0);
    issue(OPC_BR, 1'b0);
    // R11: opcode scrambled outside decode and address steps
    for (int i = 0; i < 5; i++) issue(legal[i], 1'b1);
    // R1: reset in the middle of a load
    opcode = OPC_LD;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    // mixed random stream, legal and illegal, with scrambling
    for (int i = 0; i < 300; i++) begin
      logic [5:0] op;
      op = ($urandom % 4 == 0) ? 6'($urandom) : legal[$urandom % 5];
      issue(op, 1'($urandom));
    end
    @(negedge clk);
    checking = 1'b0;
    summary();
    $finish;
  end
endmodule